// File: doc/BRIEF.md
# Indexed Addressing Address Generator

This block turns one indexed-addressing postbyte of a small 8-bit controller into a 16-bit effective address. On a start pulse it samples the postbyte, the four index registers (X, Y, SP, PC) and the two accumulators. It then decodes the postbyte. Depending on the form, it pulls one or two extension bytes through a byte-fetch port and reads a 16-bit word through a memory-read port. It finishes with a one-cycle done strobe. The strobe carries the address and the number of extra cycles the form costs. For the auto-modify forms it also carries a write-back of the updated index register.

A fence input limits the block to the simple forms. While fence is set, every constant-offset form that needs extension bytes returns address zero. This includes the 16-bit indirect form. Both the fetch port and the memory port use a request/ready handshake and can stall for any number of cycles. All address arithmetic wraps modulo 2^16.

Top module: `idx_agen`

## Requirements
- R1: After a synchronous active-low reset, `done`, `wb_en`, `fetch_req` and `mem_req` are all 0.
- R2: With postbyte bit 5 = 0, the address is base + sign-extended bits 4:0. The base is chosen by bits 7:6 (0 = X, 1 = Y, 2 = SP, 3 = PC). No byte is fetched, no word is read, and `extra_cyc` = 0.
- R3: With bit 5 = 1 and bits 7:6 not equal to 11, the step comes from bits 3:0. If bit 3 is 1, the step is the 4-bit field sign-extended (-8..-1). Otherwise it is the field plus one (1..8).
- R4: In the auto-modify forms of R3, `wb_en` pulses together with `done`. At that point `wb_sel` = bits 7:6 and `wb_value` = base + step. With bit 4 = 0 the address is the new value; with bit 4 = 1 it is the old value. `extra_cyc` = 0.
- R5: With bits 7:5 = 111 and bit 2 = 0, the base is chosen by bits 4:3. If bit 1 = 1, two bytes are fetched, high byte first, and form a 16-bit offset. If bit 1 = 0, one byte is fetched and bit 0 is its sign, giving a 9-bit offset. `extra_cyc` = 1.
- R6: With bits 7:5 = 111 and bits 2:0 = 011, one 16-bit word is read at base + 16-bit offset, and that word is the address.
- R7: With bits 7:5 = 111 and bits 2:0 = 1xx, no byte is fetched. Bits 1:0 select the offset added to the base: 00 adds A zero-extended, 01 adds B zero-extended, 10 adds D = {A,B}. `extra_cyc` = 0.
- R8: With bits 7:5 = 111 and bits 2:0 = 111, one word is read at base + D, and that word is the address. `extra_cyc` = 1.
- R9: While `fence` is 1 at start, every form with bits 7:5 = 111 and bit 2 = 0 returns address 0. It fetches no byte, reads no word, and reports `extra_cyc` = 0. All other forms are unaffected by fence.
- R10: All additions wrap modulo 2^16.
- R11: `fetch_req` stays high until `fetch_ready`, and `mem_req` stays high with a stable `mem_addr` until `mem_ready`. The two requests are never high together. Stalls do not change the result.
- R12: `done` is a single-cycle pulse, and `wb_en` is never high without `done`.
- R13: A PC base uses the `idx_pc` value sampled at start. Every one of the 256 postbytes, with fence both 0 and 1, matches the rules above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin one address computation (accepted when idle) |
| postbyte | input | 8 | Indexed-mode postbyte |
| fence | input | 1 | Forces extension-byte offset forms to address 0 |
| idx_x | input | AW | Index register X |
| idx_y | input | AW | Index register Y |
| idx_sp | input | AW | Stack pointer |
| idx_pc | input | AW | Program counter (address following the postbyte) |
| acc_a | input | 8 | Accumulator A |
| acc_b | input | 8 | Accumulator B |
| fetch_req | output | 1 | Request for the next extension byte |
| fetch_ready | input | 1 | Extension byte present on fetch_byte |
| fetch_byte | input | 8 | Extension byte |
| mem_req | output | 1 | Request for a 16-bit word read |
| mem_addr | output | AW | Word read address |
| mem_ready | input | 1 | Word present on mem_word |
| mem_word | input | AW | Word read data |
| done | output | 1 | Result valid for one cycle |
| eff_addr | output | AW | Effective address |
| extra_cyc | output | XW | Extra cycles the form costs |
| wb_en | output | 1 | Index register write-back strobe |
| wb_sel | output | 2 | Register written back (0 = X, 1 = Y, 2 = SP, 3 = PC) |
| wb_value | output | AW | Value written back |

## Verification
The bench builds the block with its default parameters: a 16-bit address width and a 2-bit extra-cycle count. With these defaults, register values near 0xFFFF and large negative offsets cover the wrap of every adder path. An exhaustive pass over all 256 postbytes, with fence both clear and set, checks every decode branch against an independent model. That pass also varies the stall lengths on the fetch and memory ports.

// File: rtl/idx_agen_pkg.sv
// Shared types for the indexed address generator.
// Assumes bytes are 8 bits wide and the postbyte layout is fixed.
package idx_agen_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        AM_CONST5,
        AM_AUTO,
        AM_OFFSET,
        AM_ACCUM,
        AM_FENCED
    } amode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROUTE,
        ST_FHI,
        ST_FLO,
        ST_SUM,
        ST_MEM,
        ST_DONE
    } state_e;
endpackage

// File: rtl/idx_decode.sv
// Postbyte decoder: classifies the indexed form and extracts its fields.
// Purely combinational. Assumes AW >= 16.
module idx_decode
    import idx_agen_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [BYTE_W-1:0] pb,
    input  logic              fence,
    output amode_e            mode,
    output logic [1:0]        base_sel,
    output logic [AW-1:0]     imm,
    output logic              post,
    output logic [1:0]        n_ext,
    output logic              indirect,
    output logic [1:0]        acc_sel,
    output logic              extra
);
    // Classify the postbyte and derive base, immediate and fetch needs
    always_comb begin
        mode     = AM_CONST5;
        base_sel = pb[7:6];
        imm      = '0;
        post     = 1'b0;
        n_ext    = 2'd0;
        indirect = 1'b0;
        acc_sel  = pb[1:0];
        extra    = 1'b0;
        if (!pb[5]) begin
            mode = AM_CONST5;
            imm  = {{(AW-5){pb[4]}}, pb[4:0]};
        end else if (pb[7:6] != 2'b11) begin
            mode = AM_AUTO;
            post = pb[4];
            imm  = pb[3] ? {{(AW-4){1'b1}}, pb[3:0]}
                         : {{(AW-3){1'b0}}, pb[2:0]} + AW'(1);
        end else begin
            base_sel = pb[4:3];
            if (!pb[2]) begin
                if (fence) begin
                    mode = AM_FENCED;
                end else begin
                    mode     = AM_OFFSET;
                    n_ext    = pb[1] ? 2'd2 : 2'd1;
                    indirect = (pb[1:0] == 2'b11);
                    extra    = 1'b1;
                end
            end else begin
                mode     = AM_ACCUM;
                indirect = (pb[1:0] == 2'b11);
                extra    = indirect;
            end
        end
    end
endmodule

// File: rtl/idx_offset_sel.sv
// Offset selector: picks the value added to the base register.
// Purely combinational. Extension bytes are meaningful only in offset mode.
module idx_offset_sel
    import idx_agen_pkg::*;
#(
    parameter int AW = 16
) (
    input  amode_e            mode,
    input  logic [1:0]        acc_sel,
    input  logic [1:0]        n_ext,
    input  logic              sign9,
    input  logic [AW-1:0]     imm,
    input  logic [BYTE_W-1:0] ext_hi,
    input  logic [BYTE_W-1:0] ext_lo,
    input  logic [BYTE_W-1:0] acc_a,
    input  logic [BYTE_W-1:0] acc_b,
    output logic [AW-1:0]     off
);
    // Choose the offset source for the active form
    always_comb begin
        unique case (mode)
            AM_ACCUM: begin
                unique case (acc_sel)
                    2'b00:   off = AW'(acc_a);
                    2'b01:   off = AW'(acc_b);
                    default: off = AW'({acc_a, acc_b});
                endcase
            end
            AM_OFFSET: begin
                if (n_ext == 2'd2) off = AW'({ext_hi, ext_lo});
                else               off = {{(AW-BYTE_W){sign9}}, ext_lo};
            end
            default: off = imm;
        endcase
    end
endmodule

// File: rtl/idx_agen.sv
// Indexed effective-address generator.
// Samples postbyte and registers on start, fetches extension bytes and an
// optional indirect word through request/ready ports, then pulses done.
// Assumes start is only raised while the block is idle.
module idx_agen
    import idx_agen_pkg::*;
#(
    parameter int AW = 16,
    parameter int XW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        postbyte,
    input  logic              fence,
    input  logic [AW-1:0]     idx_x,
    input  logic [AW-1:0]     idx_y,
    input  logic [AW-1:0]     idx_sp,
    input  logic [AW-1:0]     idx_pc,
    input  logic [7:0]        acc_a,
    input  logic [7:0]        acc_b,
    output logic              fetch_req,
    input  logic              fetch_ready,
    input  logic [7:0]        fetch_byte,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    input  logic              mem_ready,
    input  logic [AW-1:0]     mem_word,
    output logic              done,
    output logic [AW-1:0]     eff_addr,
    output logic [XW-1:0]     extra_cyc,
    output logic              wb_en,
    output logic [1:0]        wb_sel,
    output logic [AW-1:0]     wb_value
);
    localparam int NREG = 4;

    state_e             state;
    logic [7:0]         pb_q;
    logic               fence_q;
    logic [AW-1:0]      regs_q [NREG];
    logic [7:0]         a_q, b_q;
    logic [7:0]         hi_q, lo_q;
    logic [AW-1:0]      addr_q, ea_q, wbv_q;
    logic [XW-1:0]      xc_q;
    logic               wb_flag;

    amode_e             dec_mode;
    logic [1:0]         dec_base, dec_nx, dec_acc;
    logic [AW-1:0]      dec_imm, off, base_val, sum;
    logic               dec_post, dec_ind, dec_extra;

    idx_decode #(.AW(AW)) dec_i (
        .pb(pb_q), .fence(fence_q), .mode(dec_mode), .base_sel(dec_base),
        .imm(dec_imm), .post(dec_post), .n_ext(dec_nx), .indirect(dec_ind),
        .acc_sel(dec_acc), .extra(dec_extra)
    );

    idx_offset_sel #(.AW(AW)) off_i (
        .mode(dec_mode), .acc_sel(dec_acc), .n_ext(dec_nx), .sign9(pb_q[0]),
        .imm(dec_imm), .ext_hi(hi_q), .ext_lo(lo_q), .acc_a(a_q), .acc_b(b_q),
        .off(off)
    );

    // Single shared adder: selected base plus selected offset, wrapping
    always_comb begin
        base_val = regs_q[dec_base];
        sum      = base_val + off;
    end

    // Sequencer: sample, route by form, fetch bytes, read word, report
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            pb_q    <= '0;
            fence_q <= 1'b0;
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
            a_q     <= '0;
            b_q     <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
            addr_q  <= '0;
            ea_q    <= '0;
            wbv_q   <= '0;
            xc_q    <= '0;
            wb_flag <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        pb_q      <= postbyte;
                        fence_q   <= fence;
                        regs_q[0] <= idx_x;
                        regs_q[1] <= idx_y;
                        regs_q[2] <= idx_sp;
                        regs_q[3] <= idx_pc;
                        a_q       <= acc_a;
                        b_q       <= acc_b;
                        wb_flag   <= 1'b0;
                        state     <= ST_ROUTE;
                    end
                end
                ST_ROUTE: begin
                    xc_q <= XW'(dec_extra);
                    unique case (dec_mode)
                        AM_CONST5: begin
                            ea_q  <= sum;
                            state <= ST_DONE;
                        end
                        AM_AUTO: begin
                            ea_q    <= dec_post ? base_val : sum;
                            wbv_q   <= sum;
                            wb_flag <= 1'b1;
                            state   <= ST_DONE;
                        end
                        AM_FENCED: begin
                            ea_q  <= '0;
                            state <= ST_DONE;
                        end
                        AM_OFFSET: begin
                            state <= (dec_nx == 2'd2) ? ST_FHI : ST_FLO;
                        end
                        default: begin
                            if (dec_ind) begin
                                addr_q <= sum;
                                state  <= ST_MEM;
                            end else begin
                                ea_q  <= sum;
                                state <= ST_DONE;
                            end
                        end
                    endcase
                end
                ST_FHI: begin
                    if (fetch_ready) begin
                        hi_q  <= fetch_byte;
                        state <= ST_FLO;
                    end
                end
                ST_FLO: begin
                    if (fetch_ready) begin
                        lo_q  <= fetch_byte;
                        state <= ST_SUM;
                    end
                end
                ST_SUM: begin
                    if (dec_ind) begin
                        addr_q <= sum;
                        state  <= ST_MEM;
                    end else begin
                        ea_q  <= sum;
                        state <= ST_DONE;
                    end
                end
                ST_MEM: begin
                    if (mem_ready) begin
                        ea_q  <= mem_word;
                        state <= ST_DONE;
                    end
                end
                default: begin
                    wb_flag <= 1'b0;
                    state   <= ST_IDLE;
                end
            endcase
        end
    end

    // Port drive from sequencer state and result registers
    always_comb begin
        fetch_req = (state == ST_FHI) || (state == ST_FLO);
        mem_req   = (state == ST_MEM);
        mem_addr  = addr_q;
        done      = (state == ST_DONE);
        eff_addr  = ea_q;
        extra_cyc = xc_q;
        wb_en     = done && wb_flag;
        wb_sel    = dec_base;
        wb_value  = wbv_q;
    end

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12
    wb_only_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> done);

    // R11
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !fetch_ready) |=> fetch_req);

    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

    // R11
    req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_req && mem_req));

    // R9
    fence_nofetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> !fence_q);

    // R5
    extra_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (extra_cyc <= XW'(1)));
endmodule

// File: tb/idx_agen_tb.sv
// Directed bench for idx_agen with an independent address model.
module idx_agen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int XW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [7:0]    postbyte = '0;
    logic          fence = 1'b0;
    logic [AW-1:0] idx_x = 16'h1234, idx_y = 16'hFFF8, idx_sp = 16'h0800, idx_pc = 16'h8002;
    logic [7:0]    acc_a = 8'h9C, acc_b = 8'h47;
    logic          fetch_req, fetch_ready = 1'b0;
    logic [7:0]    fetch_byte = '0;
    logic          mem_req, mem_ready = 1'b0;
    logic [AW-1:0] mem_addr, mem_word = '0;
    logic          done, wb_en;
    logic [AW-1:0] eff_addr, wb_value;
    logic [XW-1:0] extra_cyc;
    logic [1:0]    wb_sel;

    int checks = 0;
    int errors = 0;
    int fstall = 0, mstall = 0, fcnt = 0, mcnt = 0, nf_seen = 0, nm_seen = 0;
    logic [7:0] eb0 = 8'hF0, eb1 = 8'h21;

    always #(CLK_PERIOD/2) clk = ~clk;

    idx_agen #(.AW(AW), .XW(XW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .postbyte(postbyte), .fence(fence),
        .idx_x(idx_x), .idx_y(idx_y), .idx_sp(idx_sp), .idx_pc(idx_pc),
        .acc_a(acc_a), .acc_b(acc_b),
        .fetch_req(fetch_req), .fetch_ready(fetch_ready), .fetch_byte(fetch_byte),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready), .mem_word(mem_word),
        .done(done), .eff_addr(eff_addr), .extra_cyc(extra_cyc),
        .wb_en(wb_en), .wb_sel(wb_sel), .wb_value(wb_value)
    );

    function automatic logic [15:0] memw(input logic [15:0] a);
        return {a[7:0] ^ 8'h5A, a[15:8] ^ 8'h3C};
    endfunction

    function automatic logic [15:0] regv(input logic [1:0] c);
        case (c)
            2'd0: return idx_x;
            2'd1: return idx_y;
            2'd2: return idx_sp;
            default: return idx_pc;
        endcase
    endfunction

    // Byte-fetch responder with programmable stall
    always @(negedge clk) begin
        if (fetch_ready) begin
            fetch_ready <= 1'b0;
            fcnt <= 0;
        end else if (fetch_req) begin
            if (fcnt >= fstall) begin
                fetch_ready <= 1'b1;
                fetch_byte  <= (nf_seen == 0) ? eb0 : eb1;
                nf_seen     <= nf_seen + 1;
            end else fcnt <= fcnt + 1;
        end
    end

    // Word-read responder with programmable stall
    always @(negedge clk) begin
        if (mem_ready) begin
            mem_ready <= 1'b0;
            mcnt <= 0;
        end else if (mem_req) begin
            if (mcnt >= mstall) begin
                mem_ready <= 1'b1;
                mem_word  <= memw(mem_addr);
                nm_seen   <= nm_seen + 1;
            end else mcnt <= mcnt + 1;
        end
    end

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference model written from the requirement list
    task automatic model(input logic [7:0] pb, input logic fz, output logic [15:0] ea, output int xc,
                         output int nf, output int nm, output logic wb, output logic [15:0] wbv);
        logic [15:0] base, st, off, s;
        ea = 0; xc = 0; nf = 0; nm = 0; wb = 0; wbv = 0;
        if (!pb[5]) begin
            ea = regv(pb[7:6]) + {{11{pb[4]}}, pb[4:0]};
        end else if (pb[7:6] != 2'b11) begin
            base = regv(pb[7:6]);
            st = pb[3] ? {12'hFFF, pb[3:0]} : {13'd0, pb[2:0]} + 16'd1;
            wb = 1; wbv = base + st;
            ea = pb[4] ? base : wbv;
        end else begin
            base = regv(pb[4:3]);
            if (!pb[2]) begin
                if (!fz) begin
                    xc = 1;
                    if (pb[1]) begin off = {eb0, eb1}; nf = 2; end
                    else begin off = {{8{pb[0]}}, eb0}; nf = 1; end
                    s = base + off;
                    if (pb[1:0] == 2'b11) begin ea = memw(s); nm = 1; end
                    else ea = s;
                end
            end else begin
                case (pb[1:0])
                    2'b00: ea = base + {8'd0, acc_a};
                    2'b01: ea = base + {8'd0, acc_b};
                    2'b10: ea = base + {acc_a, acc_b};
                    default: begin ea = memw(base + {acc_a, acc_b}); nm = 1; xc = 1; end
                endcase
            end
        end
    endtask

    task automatic run(input logic [7:0] pb, input logic fz, input int stall, input string req);
        logic [15:0] e_ea, e_wbv;
        int e_xc, e_nf, e_nm, n;
        logic e_wb;
        model(pb, fz, e_ea, e_xc, e_nf, e_nm, e_wb, e_wbv);
        @(negedge clk);
        postbyte = pb; fence = fz; fstall = stall; mstall = stall;
        nf_seen = 0; nm_seen = 0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 200) begin @(negedge clk); n++; end
        check(req, "done seen", done, 1'b1);
        check(req, "eff_addr", eff_addr, e_ea);
        check(req, "extra_cyc", extra_cyc, e_xc);
        check(req, "bytes fetched", nf_seen, e_nf);
        check(req, "words read", nm_seen, e_nm);
        check(req, "wb_en", wb_en, e_wb);
        if (e_wb) begin
            check(req, "wb_sel", wb_sel, pb[7:6]);
            check(req, "wb_value", wb_value, e_wbv);
        end
        @(negedge clk);
        check("R12", "done one cycle", done, 1'b0);
        check("R12", "wb_en after done", wb_en, 1'b0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "done", done, 0);
        check("R1", "wb_en", wb_en, 0);
        check("R1", "fetch_req", fetch_req, 0);
        check("R1", "mem_req", mem_req, 0);
    endtask

    task automatic t_const5();
        run(8'h0F, 0, 0, "R2");
        run(8'h50, 0, 0, "R2");
        run(8'h81, 0, 0, "R2");
        run(8'hDF, 0, 0, "R13");
        run(8'h4F, 0, 0, "R10");
    endtask

    task automatic t_auto();
        for (int s = 0; s < 16; s++) begin
            run({2'(s % 3), 1'b1, 1'b0, 4'(s)}, 0, 0, "R3");
            run({2'(s % 3), 1'b1, 1'b1, 4'(s)}, 0, 0, "R4");
        end
    endtask

    task automatic t_offset();
        run(8'hE0, 0, 0, "R5");
        run(8'hE1, 0, 0, "R5");
        run(8'hEA, 0, 0, "R10");
        run(8'hF2, 0, 0, "R5");
    endtask

    task automatic t_ind16();
        run(8'hE3, 0, 0, "R6");
        run(8'hFB, 0, 0, "R6");
    endtask

    task automatic t_acc();
        run(8'hE4, 0, 0, "R7");
        run(8'hED, 0, 0, "R7");
        run(8'hF6, 0, 0, "R7");
        run(8'hE7, 0, 0, "R8");
        run(8'hFF, 0, 0, "R8");
    endtask

    task automatic t_fence();
        run(8'hE3, 1, 0, "R9");
        run(8'hE0, 1, 0, "R9");
        run(8'hEA, 1, 0, "R9");
        run(8'hE4, 1, 0, "R9");
        run(8'hE7, 1, 0, "R9");
        run(8'h0F, 1, 0, "R9");
    endtask

    task automatic t_stall();
        run(8'hEA, 0, 3, "R11");
        run(8'hE7, 0, 4, "R11");
        run(8'hE3, 0, 2, "R11");
    endtask

    task automatic t_sweep();
        for (int p = 0; p < 256; p++)
            for (int f = 0; f < 2; f++)
                run(8'(p), f[0], p % 3, "R13");
    endtask

    initial begin
        t_reset();
        t_const5();
        t_auto();
        t_offset();
        t_ind16();
        t_acc();
        t_fence();
        t_stall();
        t_sweep();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL R12 watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule